// File: doc/BRIEF.md
# Transmit Pad, FCS and Length-Limit Stage

This stage sits in the transmit path between a byte source and the MAC transmitter. Frames arrive as a valid/ready byte stream, one byte per beat. A last marker ends each frame, and three per-frame control bits travel alongside the bytes. The stage passes data through without added latency. It then adds zero pad bytes to short frames, appends an IEEE 802.3 CRC-32 frame check sequence, and cuts oversized frames at a programmable length limit.

The per-frame controls are pad-plus-check, check-only and allow-oversize. They take effect only from the first byte of a frame. Three global enables take precedence over them. When a frame ends, the stage reports a one-cycle status word. That word gives the emitted length, whether the frame was cut, and whether padding was added.

Top module: `txfcs_stage`

## Requirements
- R1: In pad mode, zero bytes follow the data until data plus pad reaches 60 bytes, so the frame including its 4 check bytes is exactly 64 bytes. A frame with 60 or more data bytes gets no pad.
- R2: When the per-frame pad-plus-check bit is set, the check sequence is appended and padding applies, whatever the value of the per-frame check-only bit.
- R3: With only the per-frame check-only bit set, the check sequence is appended and no pad is added. With neither bit set and no global enable, the frame ends at its last data byte, and the reported length equals the number of data bytes.
- R4: The per-frame pad-plus-check, check-only and allow-oversize inputs are sampled on the first byte of a frame only. Their values on later bytes have no effect on the output bytes or the status.
- R5: The global pad-plus-check enable forces padding and the check sequence. Otherwise, the global check enable forces the check sequence without padding. In both cases the per-frame pad and check bits are ignored. The global oversize enable makes the per-frame allow-oversize bit irrelevant.
- R6: When oversize frames are not allowed, the emitted frame, check bytes included, never exceeds the programmed maximum length. A longer frame is cut at that limit: its remaining input bytes are consumed and dropped, and the truncation status bit is set.
- R7: When oversize frames are allowed, either globally or by the first-byte bit, frames longer than the maximum pass unmodified and the truncation bit stays clear.
- R8: The check sequence is the complement of a CRC-32 (polynomial 0x04C11DB7, reflected, register preset to all ones) taken over data and pad bytes. It is sent least significant byte first, and outLast marks its final byte. The 9 ASCII bytes "123456789" give 0xCBF43926.
- R9: stsValid is high for exactly one cycle after the final byte of a frame. It is accompanied by stsLen (total emitted bytes including check bytes), stsTrunc and stsPadded.
- R10: After reset, outValid and stsValid are low and the stage is ready to begin a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPadCrcAll | input | 1 | Global pad-plus-check enable |
| cfgCrcAll | input | 1 | Global check-sequence enable |
| cfgHugeAll | input | 1 | Global allow-oversize enable |
| cfgMaxLen | input | LEN_W | Maximum frame length in bytes, check bytes included |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Stage accepts the input byte |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Input byte is the last of its frame |
| inPadCrc | input | 1 | Per-frame pad-plus-check request |
| inCrc | input | 1 | Per-frame check-only request |
| inHuge | input | 1 | Per-frame allow-oversize request |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts the output byte |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Output byte is the last of its frame |
| stsValid | output | 1 | One-cycle frame status strobe |
| stsLen | output | LEN_W | Emitted frame length |
| stsTrunc | output | 1 | Frame was cut at the maximum length |
| stsPadded | output | 1 | Pad bytes were added |

## Verification
The assertions take for granted that cfgMaxLen is at least 64 and that the global enables and cfgMaxLen stay constant while a frame is in flight. They also assume frames are shorter than the counter range. The stimulus changes configuration only between frames, once the status strobe has been seen, and it keeps the limit at 64 or above. Every byte after the first carries the inverse of the first byte's per-frame bits. Part of the sweep stalls the output side with a pseudo-random ready pattern.

// File: rtl/txfcs_pkg.sv
package txfcs_pkg;
  localparam int FCS_BYTES = 4;

  typedef enum logic [2:0] {
    ST_DATA,
    ST_DROP,
    ST_PAD,
    ST_FCS,
    ST_STAT
  } txState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic       crcInit;
    logic       crcUpd;
    logic       selPad;
    logic       selFcs;
    logic [1:0] fcsIdx;
  } dpCtl_t;
endpackage

// File: rtl/txfcs_datapath.sv
module txfcs_datapath
  import txfcs_pkg::*;
#(
  parameter logic [31:0] POLY_REFL = 32'hEDB88320
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic [7:0] inData,
  output logic [7:0] outData
);
  logic [31:0] crcQ;
  logic [31:0] crcNext;
  logic [31:0] fcsWord;
  logic [7:0]  feedByte;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign feedByte = ctl.selPad ? 8'h00 : inData;
  assign crcNext  = crcStep(crcQ, feedByte);
  assign fcsWord  = ~crcQ;

  always_ff @(posedge clk) begin
    if (!rstN)            crcQ <= '1;
    else if (ctl.crcInit) crcQ <= '1;
    else if (ctl.crcUpd)  crcQ <= crcNext;
  end

  always_comb begin
    if (ctl.selFcs)      outData = fcsWord[8*ctl.fcsIdx +: 8];
    else if (ctl.selPad) outData = 8'h00;
    else                 outData = inData;
  end

  // R8
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.selPad, ctl.selFcs}));

  // R8
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.crcInit |=> (crcQ == 32'hFFFF_FFFF));
endmodule

// File: rtl/txfcs_ctrl.sv
module txfcs_ctrl
  import txfcs_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MIN_FRAME = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgPadCrcAll,
  input  logic             cfgCrcAll,
  input  logic             cfgHugeAll,
  input  logic [LEN_W-1:0] cfgMaxLen,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inLast,
  input  logic             inPadCrc,
  input  logic             inCrc,
  input  logic             inHuge,
  output logic             outValid,
  input  logic             outReady,
  output logic             outLast,
  output logic             stsValid,
  output logic [LEN_W-1:0] stsLen,
  output logic             stsTrunc,
  output logic             stsPadded,
  output dpCtl_t           ctl
);
  localparam logic [LEN_W-1:0] PAD_TARGET = LEN_W'(MIN_FRAME - FCS_BYTES);
  localparam logic [LEN_W-1:0] FCS_LEN    = LEN_W'(FCS_BYTES);

  txState_t         state;
  logic [LEN_W-1:0] cnt;
  logic [1:0]       fcsIdx;
  logic             padQ, fcsQ, hugeQ, truncQ, paddedQ;

  logic             firstByte, padNow, fcsNow, hugeNow;
  logic [LEN_W-1:0] capLen, cntNext;
  logic             dataFire, cutHere;

  always_comb begin
    firstByte = (state == ST_DATA) && (cnt == '0);
    padNow    = firstByte ? (cfgPadCrcAll | (~cfgCrcAll & inPadCrc)) : padQ;
    fcsNow    = firstByte ? (cfgPadCrcAll | cfgCrcAll | inPadCrc | inCrc) : fcsQ;
    hugeNow   = firstByte ? (cfgHugeAll | inHuge) : hugeQ;
    capLen    = fcsNow ? (cfgMaxLen - FCS_LEN) : cfgMaxLen;
    cntNext   = cnt + 1'b1;
    dataFire  = (state == ST_DATA) && inValid && outReady;
    cutHere   = ~hugeNow && (cntNext == capLen) && ~inLast;
  end

  always_comb begin
    inReady  = 1'b0;
    outValid = 1'b0;
    outLast  = 1'b0;
    unique case (state)
      ST_DATA: begin
        inReady  = outReady;
        outValid = inValid;
        outLast  = ~fcsNow & (inLast | cutHere);
      end
      ST_DROP: inReady = 1'b1;
      ST_PAD:  outValid = 1'b1;
      ST_FCS: begin
        outValid = 1'b1;
        outLast  = (fcsIdx == 2'd3);
      end
      default: ;
    endcase
  end

  always_comb begin
    ctl.crcInit = (state == ST_STAT);
    ctl.crcUpd  = dataFire || ((state == ST_PAD) && outReady);
    ctl.selPad  = (state == ST_PAD);
    ctl.selFcs  = (state == ST_FCS);
    ctl.fcsIdx  = fcsIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_DATA;
      cnt     <= '0;
      fcsIdx  <= '0;
      padQ    <= 1'b0;
      fcsQ    <= 1'b0;
      hugeQ   <= 1'b0;
      truncQ  <= 1'b0;
      paddedQ <= 1'b0;
    end else begin
      unique case (state)
        ST_DATA: if (dataFire) begin
          cnt <= cntNext;
          if (firstByte) begin
            padQ  <= padNow;
            fcsQ  <= fcsNow;
            hugeQ <= hugeNow;
          end
          if (cutHere) begin
            truncQ <= 1'b1;
            state  <= ST_DROP;
          end else if (inLast) begin
            if (padNow && (cntNext < PAD_TARGET)) begin
              paddedQ <= 1'b1;
              state   <= ST_PAD;
            end else if (fcsNow) state <= ST_FCS;
            else                 state <= ST_STAT;
          end
        end
        ST_DROP: if (inValid && inLast) state <= fcsQ ? ST_FCS : ST_STAT;
        ST_PAD: if (outReady) begin
          cnt <= cntNext;
          if (cntNext == PAD_TARGET) state <= ST_FCS;
        end
        ST_FCS: if (outReady) begin
          fcsIdx <= fcsIdx + 2'd1;
          if (fcsIdx == 2'd3) state <= ST_STAT;
        end
        ST_STAT: begin
          state   <= ST_DATA;
          cnt     <= '0;
          fcsIdx  <= '0;
          truncQ  <= 1'b0;
          paddedQ <= 1'b0;
        end
        default: state <= ST_DATA;
      endcase
    end
  end

  assign stsValid  = (state == ST_STAT);
  assign stsLen    = cnt + (fcsQ ? FCS_LEN : '0);
  assign stsTrunc  = truncQ;
  assign stsPadded = paddedQ;

  // R9
  sts_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    stsValid |=> !stsValid);

  // R6
  len_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsValid && !hugeQ) |-> (stsLen <= cfgMaxLen));

  // R1
  pad_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsValid && padQ) |-> (stsLen >= LEN_W'(MIN_FRAME)));

  // R8
  fcs_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FCS && fcsIdx == 2'd3 && outReady) |=> stsValid);
endmodule

// File: rtl/txfcs_stage.sv
module txfcs_stage
  import txfcs_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MIN_FRAME = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgPadCrcAll,
  input  logic             cfgCrcAll,
  input  logic             cfgHugeAll,
  input  logic [LEN_W-1:0] cfgMaxLen,
  input  logic             inValid,
  output logic             inReady,
  input  logic [7:0]       inData,
  input  logic             inLast,
  input  logic             inPadCrc,
  input  logic             inCrc,
  input  logic             inHuge,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outData,
  output logic             outLast,
  output logic             stsValid,
  output logic [LEN_W-1:0] stsLen,
  output logic             stsTrunc,
  output logic             stsPadded
);
  dpCtl_t ctl;

  txfcs_ctrl #(.LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgPadCrcAll(cfgPadCrcAll), .cfgCrcAll(cfgCrcAll), .cfgHugeAll(cfgHugeAll),
    .cfgMaxLen(cfgMaxLen),
    .inValid(inValid), .inReady(inReady), .inLast(inLast),
    .inPadCrc(inPadCrc), .inCrc(inCrc), .inHuge(inHuge),
    .outValid(outValid), .outReady(outReady), .outLast(outLast),
    .stsValid(stsValid), .stsLen(stsLen), .stsTrunc(stsTrunc), .stsPadded(stsPadded),
    .ctl(ctl)
  );

  txfcs_datapath uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .outData(outData)
  );

  // R1
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.selPad && outValid) |-> (outData == 8'h00));
endmodule

// File: tb/sim_txfcs_stage.sv
module sim_txfcs_stage;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgPadCrcAll = 0, cfgCrcAll = 0, cfgHugeAll = 0;
  logic [LEN_W-1:0] cfgMaxLen = 16'd1518;
  logic inValid = 0, inLast = 0, inPadCrc = 0, inCrc = 0, inHuge = 0;
  logic [7:0] inData = 0;
  logic inReady, outValid, outLast, stsValid, stsTrunc, stsPadded;
  logic outReady = 1'b1;
  logic [7:0] outData;
  logic [LEN_W-1:0] stsLen;

  always #4 clk = ~clk;

  txfcs_stage u0 (
    .clk(clk), .rstN(rstN),
    .cfgPadCrcAll(cfgPadCrcAll), .cfgCrcAll(cfgCrcAll), .cfgHugeAll(cfgHugeAll),
    .cfgMaxLen(cfgMaxLen),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inLast(inLast),
    .inPadCrc(inPadCrc), .inCrc(inCrc), .inHuge(inHuge),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast),
    .stsValid(stsValid), .stsLen(stsLen), .stsTrunc(stsTrunc), .stsPadded(stsPadded)
  );

  int nTests = 0, nFail = 0;
  int cycles = 0;
  bit stallMode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] dIn [0:255];
  logic [7:0] expB [0:511];
  logic [7:0] obuf [0:511];
  int obN, lastCnt, lastPos;
  bit stsSeen;
  logic [LEN_W-1:0] gotLen;
  logic gotTrunc, gotPad;

  // output-side ready pattern, driven away from the edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    outReady = stallMode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (outValid && outReady) begin
      if (obN < 512) obuf[obN] = outData;
      if (outLast) begin lastCnt++; lastPos = obN; end
      obN++;
    end
    if (stsValid) begin
      stsSeen  = 1;
      gotLen   = stsLen;
      gotTrunc = stsTrunc;
      gotPad   = stsPadded;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nTests++; nFail++;
      $display("FAIL watchdog: run did not finish, act=%0d cycles exp<190000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] refCrc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ expB[i][b]) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
      end
    return ~c;
  endfunction

  // Send dIn[0..len-1]; per-frame bits only on byte 0, inverted afterwards (R4)
  task automatic runFrame(input int len, input bit pPad, input bit pCrc, input bit pHuge,
                          input string tag);
    bit fcs, pad, huge, trunc;
    int cap, n, expN, padN;
    logic [31:0] f;
    // expected behaviour (R1, R2, R3, R5, R6, R7)
    if (cfgPadCrcAll)   begin pad = 1; fcs = 1; end
    else if (cfgCrcAll) begin pad = 0; fcs = 1; end
    else                begin pad = pPad; fcs = pPad | pCrc; end
    huge  = cfgHugeAll | pHuge;
    cap   = fcs ? int'(cfgMaxLen) - 4 : int'(cfgMaxLen);
    trunc = !huge && len > cap;
    n     = trunc ? cap : len;
    padN  = (pad && n < 60) ? 60 - n : 0;
    for (int i = 0; i < n; i++) expB[i] = dIn[i];
    for (int i = 0; i < padN; i++) expB[n+i] = 8'h00;
    expN = n + padN;
    if (fcs) begin
      f = refCrc(expN);
      for (int k = 0; k < 4; k++) expB[expN+k] = f[8*k +: 8];
      expN += 4;
    end

    obN = 0; lastCnt = 0; lastPos = -1; stsSeen = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      inValid = 1; inData = dIn[i]; inLast = (i == len - 1);
      inPadCrc = (i == 0) ? pPad : ~pPad;
      inCrc    = (i == 0) ? pCrc : ~pCrc;
      inHuge   = (i == 0) ? pHuge : ~pHuge;
      @(negedge clk);
      while (!inReady) @(negedge clk);
    end
    @(posedge clk); #1;
    inValid = 0; inLast = 0;
    while (!stsSeen) @(negedge clk);

    begin
      bit ok = (obN == expN);
      int bad = -1;
      if (ok) for (int i = 0; i < expN; i++)
        if (obuf[i] !== expB[i] && bad < 0) bad = i;
      if (bad >= 0) ok = 0;
      check(ok, {tag, " stream R1 R3 R8"}, bad < 0 ? obN : obuf[bad], bad < 0 ? expN : expB[bad]);
    end
    // R8 outLast on final emitted byte only
    check(lastCnt == 1 && lastPos == expN - 1, {tag, " outLast R8"}, lastPos, expN - 1);
    // R9 status contents, R6/R7 truncation flag
    check(gotLen == LEN_W'(expN) && gotTrunc == trunc && gotPad == (padN > 0),
          {tag, " status R9 R6 R7"}, {gotLen, gotTrunc, gotPad},
          {LEN_W'(expN), trunc, padN > 0});
  endtask

  task automatic fillData(input int len, input int seed);
    for (int i = 0; i < len; i++) dIn[i] = 8'((seed * 29 + i * 13 + (i >> 3)) ^ 8'h5A);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R10 reset state
    check(!outValid && !stsValid && inReady, "reset R10", {outValid, stsValid, inReady}, 3'b001);

    // R8 known check value
    cfgCrcAll = 1;
    for (int i = 0; i < 9; i++) dIn[i] = 8'h31 + 8'(i);
    runFrame(9, 1, 0, 0, "crc_vec");
    check({obuf[12], obuf[11], obuf[10], obuf[9]} == 32'hCBF43926, "crc vector R8",
          {obuf[12], obuf[11], obuf[10], obuf[9]}, 32'hCBF43926);
    cfgCrcAll = 0;

    // sweep: global mode x per-frame bits x length (R1 R2 R3 R4 R5)
    for (int g = 0; g < 3; g++) begin
      cfgCrcAll    = (g == 1);
      cfgPadCrcAll = (g == 2);
      for (int m = 0; m < 4; m++)
        for (int len = 1; len <= 66; len++) begin
          fillData(len, len + m * 7 + g * 3);
          stallMode = (len % 5 == 0);
          runFrame(len, m[1], m[0], 0, "sweep");
        end
    end
    cfgCrcAll = 0; cfgPadCrcAll = 0; stallMode = 0;

    // truncation and oversize (R6 R7), limit 70
    cfgMaxLen = 16'd70;
    for (int h = 0; h < 3; h++) begin
      cfgHugeAll = (h == 2);
      for (int f = 0; f < 2; f++)
        for (int len = 60; len <= 80; len++) begin
          fillData(len, len * 3 + f);
          stallMode = (len % 4 == 1);
          runFrame(len, 0, f[0], (h == 1), "limit");
        end
    end
    // boundary at the limit of 64 with pad enabled (R1 R6)
    cfgHugeAll = 0; cfgMaxLen = 16'd64; cfgPadCrcAll = 1;
    for (int len = 58; len <= 63; len++) begin
      fillData(len, len);
      runFrame(len, 0, 0, 0, "limit64");
    end
    summary();
  end
endmodule